// File: doc/BRIEF.md
# Link Time-Sync Requester Engine

This block runs the requester half of a timing handshake over a serial point-to-point link. When it is enabled and a trigger or its own period counter fires, it sends a request message. It latches the free-running local time in the cycle the link accepts that request. It latches the local time again in the cycle a response comes back.

A response may be a plain marker with no payload. It may instead carry the responder's 64-bit clock value and a 32-bit path delay. From the two local stamps the engine derives the round-trip interval. From a data-bearing response it also forms a corrected master time, which is the remote clock plus the path delay, and signals that time with a one-cycle valid pulse.

Three further cases are handled. A response that is not awaited is dropped and counted. A missing response ends the handshake after a programmable wait and raises an error flag. A static capability output reports the granularity of the local clock.

The transmit side is a valid/ready stream. `tx_valid` rises with the request and stays high, with `tx_kind` unchanged, until the cycle in which `tx_ready` is high. The receive side never applies back-pressure: `rx_ready` is tied high, and every cycle with `rx_valid` high is one message.

Top module: `tsync_req_engine`

## Requirements
- R1: After reset, `tx_valid`, `busy`, `time_valid` and `timeout_err` are low. `stray_count`, `t_req`, `t_rsp`, `rtt` and `master_time` are zero.
- R2: With `cfg_enable` high and the engine idle, a high `trigger` raises `tx_valid` on the next cycle with `tx_kind` = 2'b01 (request). `tx_valid` then stays high until accepted by `tx_ready`.
- R3: `t_req` takes the value of `local_time` in the cycle the request is accepted (`tx_valid` and `tx_ready` both high).
- R4: `rx_ready` is always high. While a request is outstanding, an `rx_valid` cycle with `rx_kind` 2'b10 (plain response) or 2'b11 (data response) ends the wait, and `t_rsp` takes that cycle's `local_time`.
- R5: One cycle after the response is taken, `rtt` equals `t_rsp - t_req` modulo 2^64.
- R6: For a data response, `rcv_time` and `rcv_delay` hold the message's time and delay fields. `master_time` becomes `rx_time` plus the zero-extended `rx_delay`, modulo 2^64. `time_valid` pulses for exactly one cycle, together with the new `master_time`.
- R7: A plain response updates `t_req`, `t_rsp` and `rtt` only. `master_time` is unchanged and no `time_valid` pulse occurs.
- R8: If no response arrives within `cfg_timeout` cycles of acceptance, `timeout_err` is set and the engine returns to idle. The flag clears when the next request starts.
- R9: A trigger while a handshake is in progress is ignored. No extra request follows once the handshake ends.
- R10: With `cfg_enable` low, no request starts. Dropping `cfg_enable` mid-handshake withdraws `tx_valid` and returns the engine to idle on the next cycle.
- R11: With `cfg_interval` = N > 0, a request starts every N cycles while enabled. With `cfg_interval` = 0, no periodic request starts.
- R12: A response (kind 2'b10 or 2'b11) arriving when no request is outstanding changes no timestamp or master time. It increments `stray_count`, which saturates at its maximum.
- R13: `cap_granularity` reports the local clock granularity parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_timeout | input | TOW | Response wait limit in cycles |
| cfg_interval | input | IVW | Periodic request interval, 0 = off |
| trigger | input | 1 | Start a handshake |
| local_time | input | TW | Free-running local time |
| tx_valid | output | 1 | Request message valid |
| tx_ready | input | 1 | Link accepts request |
| tx_kind | output | 2 | Outgoing message kind (2'b01) |
| rx_valid | input | 1 | Incoming message valid |
| rx_ready | output | 1 | Always high |
| rx_kind | input | 2 | Incoming kind: 2'b10 plain, 2'b11 data |
| rx_time | input | TW | Remote time field |
| rx_delay | input | DW | Path delay field |
| t_req | output | TW | Local stamp at request send |
| t_rsp | output | TW | Local stamp at response receipt |
| rtt | output | TW | Round-trip interval |
| rcv_time | output | TW | Last received remote time |
| rcv_delay | output | DW | Last received path delay |
| master_time | output | TW | Corrected master time |
| time_valid | output | 1 | One-cycle pulse on new master time |
| timeout_err | output | 1 | Response wait expired |
| stray_count | output | STRAY_W | Saturating count of unexpected responses |
| busy | output | 1 | Handshake in progress |
| cap_granularity | output | GRAN_W | Local clock granularity |

## Verification
The bench targets the 64-bit wrap of both the round-trip subtraction and the corrected-time sum. A design that sign-handles or truncates either value produces a huge or negative-looking interval, or the wrong master time. Plain responses are mixed with data responses. An engine that always loads the master time or always pulses valid then shows a changed `master_time` or an extra pulse. Triggers are pulsed during a wait, and responses are sent while idle to drive the stray counter past its limit. A design that restarts on a busy trigger emits a second request, and a non-saturating counter wraps to zero. The timeout is checked both before and after it expires, and the periodic counter is run with a non-zero interval and then with zero. Either check catches an engine that starts late, starts too often or never stops.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_UPD} tsync_state_e;
  localparam logic [1:0] KIND_REQ  = 2'b01;
  localparam logic [1:0] KIND_RSP  = 2'b10;
  localparam logic [1:0] KIND_RSPD = 2'b11;
endpackage

// File: rtl/tsync_interval.sv
module tsync_interval #(
  parameter int IVW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [IVW-1:0] period,
  output logic           tick
);
  logic [IVW-1:0] cnt;
  logic           off;

  assign off  = !en || (period == '0);
  assign tick = !off && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (off)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R11: a zero interval never produces a periodic start
  assert_no_tick_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !tick);
endmodule

// File: rtl/tsync_stray_ctr.sv
module tsync_stray_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (hit && !(&count)) count <= count + 1'b1;
  end

  assert_stray_inc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(&count)) |=> (count == $past(count) + 1'b1));
  assert_stray_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(count));
endmodule

// File: rtl/tsync_calc.sv
module tsync_calc #(
  parameter int TW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          with_data,
  input  logic [TW-1:0] t_tx,
  input  logic [TW-1:0] t_rx,
  input  logic [TW-1:0] r_time,
  input  logic [DW-1:0] r_delay,
  output logic [TW-1:0] rtt,
  output logic [TW-1:0] master_time,
  output logic          time_valid
);
  localparam int PADW = TW - DW;
  logic [TW-1:0] delay_ext;

  assign delay_ext = {{PADW{1'b0}}, r_delay};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtt         <= '0;
      master_time <= '0;
      time_valid  <= 1'b0;
    end else begin
      time_valid <= fire && with_data;
      if (fire) begin
        rtt <= t_rx - t_tx;
        if (with_data) master_time <= r_time + delay_ext;
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |=> !time_valid);
  assert_plain_keeps_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !with_data) |=> $stable(master_time));
endmodule

// File: rtl/tsync_req_engine.sv
module tsync_req_engine
  import tsync_pkg::*;
#(
  parameter int          TW      = 64,
  parameter int          DW      = 32,
  parameter int          TOW     = 16,
  parameter int          IVW     = 16,
  parameter int          STRAY_W = 8,
  parameter int          GRAN_W  = 8,
  parameter logic [7:0]  GRAN    = 8'd4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [TOW-1:0]     cfg_timeout,
  input  logic [IVW-1:0]     cfg_interval,
  input  logic               trigger,
  input  logic [TW-1:0]      local_time,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [1:0]         tx_kind,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [1:0]         rx_kind,
  input  logic [TW-1:0]      rx_time,
  input  logic [DW-1:0]      rx_delay,
  output logic [TW-1:0]      t_req,
  output logic [TW-1:0]      t_rsp,
  output logic [TW-1:0]      rtt,
  output logic [TW-1:0]      rcv_time,
  output logic [DW-1:0]      rcv_delay,
  output logic [TW-1:0]      master_time,
  output logic               time_valid,
  output logic               timeout_err,
  output logic [STRAY_W-1:0] stray_count,
  output logic               busy,
  output logic [GRAN_W-1:0]  cap_granularity
);
  localparam logic [TOW:0] ONE = {{TOW{1'b0}}, 1'b1};

  tsync_state_e state;
  logic [TOW-1:0] wcnt;
  logic [TOW:0]   wcnt_nx;
  logic           got_data;
  logic           tick, is_rsp, accept_rsp, stray_hit, timeout_hit, fire;

  assign is_rsp      = rx_valid && rx_kind[1];
  assign accept_rsp  = is_rsp && cfg_enable && (state == ST_WAIT);
  assign stray_hit   = is_rsp && !accept_rsp;
  assign wcnt_nx     = {1'b0, wcnt} + ONE;
  assign timeout_hit = (state == ST_WAIT) && !is_rsp && (wcnt_nx >= {1'b0, cfg_timeout});
  assign fire        = (state == ST_UPD);

  assign tx_valid        = (state == ST_SEND);
  assign tx_kind         = KIND_REQ;
  assign rx_ready        = 1'b1;
  assign busy            = (state != ST_IDLE);
  assign cap_granularity = GRAN_W'(GRAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      wcnt        <= '0;
      t_req       <= '0;
      t_rsp       <= '0;
      rcv_time    <= '0;
      rcv_delay   <= '0;
      got_data    <= 1'b0;
      timeout_err <= 1'b0;
    end else if (!cfg_enable) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (trigger || tick) begin
          state       <= ST_SEND;
          timeout_err <= 1'b0;
        end
        ST_SEND: if (tx_ready) begin
          t_req <= local_time;
          wcnt  <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (is_rsp) begin
            t_rsp    <= local_time;
            got_data <= (rx_kind == KIND_RSPD);
            if (rx_kind == KIND_RSPD) begin
              rcv_time  <= rx_time;
              rcv_delay <= rx_delay;
            end
            state <= ST_UPD;
          end else if (timeout_hit) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            wcnt <= wcnt_nx[TOW-1:0];
          end
        end
        ST_UPD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  tsync_interval #(.IVW(IVW)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .period(cfg_interval), .tick(tick)
  );

  tsync_stray_ctr #(.W(STRAY_W)) u_stray (
    .clk(clk), .rst_n(rst_n), .hit(stray_hit), .count(stray_count)
  );

  tsync_calc #(.TW(TW), .DW(DW)) u_calc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .with_data(got_data),
    .t_tx(t_req), .t_rx(t_rsp), .r_time(rcv_time), .r_delay(rcv_delay),
    .rtt(rtt), .master_time(master_time), .time_valid(time_valid)
  );

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && cfg_enable) |=> tx_valid);
  assert_treq_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |=> $stable(t_req));
  assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !busy);
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !busy);
  assert_stray_no_stamp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stray_hit |=> $stable(t_rsp));
endmodule

// File: tb/tsync_req_engine_tb.sv
`timescale 1ns/1ps
module tsync_req_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [15:0] cfg_timeout = 16'd100;
  logic [15:0] cfg_interval = 16'd0;
  logic        trigger = 1'b0;
  logic [63:0] local_time = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [1:0]  tx_kind;
  logic        rx_valid = 1'b0, rx_ready;
  logic [1:0]  rx_kind = 2'b00;
  logic [63:0] rx_time = '0;
  logic [31:0] rx_delay = '0;
  logic [63:0] t_req, t_rsp, rtt, rcv_time, master_time;
  logic [31:0] rcv_delay;
  logic        time_valid, timeout_err, busy;
  logic [2:0]  stray_count;
  logic [7:0]  cap_granularity;

  int vectors = 0;
  int fails = 0;
  int pulses = 0;
  logic [63:0] exp_master[$];
  logic [63:0] exp_rtt[$];

  always #2 clk = ~clk;

  tsync_req_engine #(.STRAY_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_timeout(cfg_timeout),
    .cfg_interval(cfg_interval), .trigger(trigger), .local_time(local_time),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_kind(rx_kind),
    .rx_time(rx_time), .rx_delay(rx_delay), .t_req(t_req), .t_rsp(t_rsp),
    .rtt(rtt), .rcv_time(rcv_time), .rcv_delay(rcv_delay),
    .master_time(master_time), .time_valid(time_valid), .timeout_err(timeout_err),
    .stray_count(stray_count), .busy(busy), .cap_granularity(cap_granularity)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // monitor: pops scoreboard on each valid pulse; R6 pulse width checked too
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (time_valid) begin
        pulses++;
        chk(!prev, "R6 single-cycle pulse", 64'(prev), 64'd0);
        if (exp_master.size() == 0) begin
          chk(1'b0, "R7 unexpected time_valid", 64'd1, 64'd0);
        end else begin
          logic [63:0] em, er;
          em = exp_master.pop_front();
          er = exp_rtt.pop_front();
          chk(master_time == em, "R6 master_time", master_time, em);
          chk(rtt == er, "R5 rtt at pulse", rtt, er);
        end
      end
      prev = time_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic start_req(input logic [63:0] ta);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    chk(tx_valid === 1'b1 && tx_kind == 2'b01, "R2 request raised", {62'd0, tx_kind}, 64'd1);
    local_time = ta; tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk(t_req == ta, "R3 t_req", t_req, ta);
  endtask

  task automatic send_rsp(input logic [1:0] kind, input logic [63:0] ta, input logic [63:0] tb4,
                          input logic [63:0] rt, input logic [31:0] rd);
    if (kind == 2'b11) begin
      exp_master.push_back(rt + {32'd0, rd});
      exp_rtt.push_back(tb4 - ta);
    end
    rx_valid = 1'b1; rx_kind = kind; rx_time = rt; rx_delay = rd; local_time = tb4;
    @(negedge clk); rx_valid = 1'b0;
    chk(t_rsp == tb4, "R4 t_rsp", t_rsp, tb4);
    @(negedge clk);
    chk(rtt == tb4 - ta, "R5 rtt", rtt, tb4 - ta);
    @(negedge clk);
  endtask

  task automatic stray(input logic [63:0] rt);
    @(negedge clk);
    rx_valid = 1'b1; rx_kind = 2'b11; rx_time = rt; rx_delay = 32'd9; local_time = 64'hDEAD;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    int n;
    logic [63:0] m0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !busy && !time_valid && !timeout_err, "R1 control outs", {60'd0, tx_valid, busy, time_valid, timeout_err}, 64'd0);
    chk(stray_count == 0 && t_req == 0 && t_rsp == 0 && rtt == 0 && master_time == 0, "R1 registers", master_time, 64'd0);
    chk(cap_granularity == 8'd4, "R13 granularity", 64'(cap_granularity), 64'd4);
    chk(rx_ready == 1'b1, "R4 rx_ready", 64'(rx_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b1;

    // R6 data response
    start_req(64'd1000);
    repeat (3) @(negedge clk);
    send_rsp(2'b11, 64'd1000, 64'd1250, 64'h0123_4567_89AB_0000, 32'h0000_0100);
    chk(rcv_time == 64'h0123_4567_89AB_0000 && rcv_delay == 32'h100, "R6 rcv fields", rcv_time, 64'h0123_4567_89AB_0000);

    // R5/R6 wrap cases
    start_req(64'hFFFF_FFFF_FFFF_FFF0);
    send_rsp(2'b11, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 32'd2);
    chk(master_time == 64'd1, "R6 master wrap", master_time, 64'd1);

    // R7 plain response
    m0 = master_time; n = pulses;
    start_req(64'd5000);
    repeat (2) @(negedge clk);
    send_rsp(2'b10, 64'd5000, 64'd5077, 64'h5555, 32'd5);
    repeat (2) @(negedge clk);
    chk(master_time == m0, "R7 master unchanged", master_time, m0);
    chk(pulses == n, "R7 no pulse", 64'(pulses), 64'(n));

    // R9 trigger during wait
    start_req(64'd7000);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    send_rsp(2'b10, 64'd7000, 64'd7100, 64'd0, 32'd0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tx_valid) n++;
    end
    chk(n == 0, "R9 busy trigger ignored", 64'(n), 64'd0);

    // R8 timeout
    cfg_timeout = 16'd10;
    start_req(64'd9000);
    repeat (5) @(negedge clk);
    chk(!timeout_err && busy, "R8 still waiting", 64'(timeout_err), 64'd0);
    repeat (10) @(negedge clk);
    chk(timeout_err && !busy, "R8 timeout flagged", 64'(timeout_err), 64'd1);

    // R12 stray while idle
    r0 = t_rsp; m0 = master_time; n = pulses;
    stray(64'h7777);
    repeat (3) @(negedge clk);
    chk(stray_count == 3'd1, "R12 stray counted", 64'(stray_count), 64'd1);
    chk(t_rsp == r0 && master_time == m0 && pulses == n, "R12 stray no effect", t_rsp, r0);

    // R8 flag cleared by next request
    cfg_timeout = 16'd100;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    chk(!timeout_err, "R8 flag cleared", 64'(timeout_err), 64'd0);
    tx_ready = 1'b1; local_time = 64'd100;
    @(negedge clk); tx_ready = 1'b0;
    send_rsp(2'b10, 64'd100, 64'd130, 64'd0, 32'd0);

    // R12 saturation
    for (int i = 0; i < 8; i++) stray(64'h8888);
    @(negedge clk);
    chk(stray_count == 3'd7, "R12 saturate", 64'(stray_count), 64'd7);

    // R10 disable
    cfg_enable = 1'b0;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    repeat (2) @(negedge clk);
    chk(!tx_valid && !busy, "R10 no start when disabled", 64'(tx_valid), 64'd0);
    cfg_enable = 1'b1;
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    chk(tx_valid, "R10 request up", 64'(tx_valid), 64'd1);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !busy, "R10 withdraw", 64'(tx_valid), 64'd0);

    // R11 periodic
    cfg_timeout = 16'd10; cfg_interval = 16'd50; tx_ready = 1'b1; cfg_enable = 1'b1;
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tx_valid) n++;
    end
    chk(n >= 9 && n <= 10, "R11 periodic count", 64'(n), 64'd10);
    cfg_interval = 16'd0;
    repeat (20) @(negedge clk);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx_valid) n++;
    end
    chk(n == 0, "R11 interval off", 64'(n), 64'd0);
    tx_ready = 1'b0;

    chk(exp_master.size() == 0, "R6 scoreboard drained", 64'(exp_master.size()), 64'd0);
    summary();
    $finish;
  end
endmodule